// File: doc/BRIEF.md
# Printer Port Register Block

This block holds the three host-visible registers of a standard printer port: the output data latch, the status register and the control register. They sit on a byte-wide host I/O bus with combinational read data and single-cycle write strobes. The block builds the values that the host reads back, forcing the bits that are fixed or unused in each operating flavour. It owns the interrupt-enable bit and the interrupt-pending flag that a peripheral acknowledge raises. It drives the data, strobe and autofeed lines toward the peripheral.

Four configuration inputs choose the flavour: plain compatibility, an extended bidirectional mode, an enhanced mode with address/data register sets, and an extended-capabilities mode. A further input marks the extended-capabilities port as running its enhanced sub-mode. The handshakes of the enhanced address/data cycles and any FIFO engine live outside this block.

Top module: `pport_regs`

## Requirements
- R1: The decoded offset is `bus_addr` when `cfg_legacy_base` is 0 and `bus_addr[1:0]` when it is 1. Offset 0 is data, 1 is status and 2 is control. Any other offset reads 0xFF, and a write to it changes nothing.
- R2: The raw control value is built as follows. With `periph_ctrl_valid` at 0 it is 0xC0 OR the stored control byte OR the interrupt enable placed at bit 4. With `periph_ctrl_valid` at 1 it is `periph_ctrl` with bit 4 replaced by the interrupt enable. Bit 5 of the raw value is always 0.
- R3: When neither `cfg_epp` nor `cfg_ecp` is set, a control read returns the raw value with bit 5 set to 1. When `cfg_ecp` is set, bits 1:0 of a control read come from the stored control byte.
- R4: A control write stores the whole byte, and bit 4 of that byte becomes the interrupt enable. `pin_strobe` follows stored bit 0 and `pin_autofeed` follows stored bit 1. A control write with bit 4 at 0 clears the pending flag.
- R5: Status bits 7:3 are `periph_status` when `periph_present` is 1 and 5'b11011 otherwise. With `cfg_ext`, `cfg_epp` and `cfg_ecp` all at 0, status bits 2:0 read 3'b111.
- R6: With `cfg_ext` at 1 and neither `cfg_epp` nor `cfg_ecp` set, status bits 2:0 are {not pending, 1, 1}. With `cfg_ext` at 1, any status read clears the pending flag on the next edge, and this takes priority over an acknowledge raise in the same cycle.
- R7: With `cfg_epp` or `cfg_ecp` set, status bit 1 is 1 and bit 0 is 0 when the enhanced register set is active (`cfg_epp`, or `cfg_ecp` together with `cfg_ecp_epp`), and 1 otherwise. Bit 2 is the inverted pending flag while the interrupt enable is 1, and reads 1 while it is 0.
- R8: A data write always updates the data latch, which a read of offset 0 returns. `pin_data` takes the written byte only when `cfg_ext` is 0 or stored control bit 5 (direction) is 0.
- R9: While the interrupt enable is 1, `ack_raise` sets the pending flag and `ack_lower` clears it, with raise winning when both are asserted. While the enable is 0 the flag is held at 0. `irq` shows the flag.
- R10: A synchronous active-high reset sets the data latch and `pin_data` to 0xFF, the control byte to 0x00, the interrupt enable to 0 and the pending flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset from the port base |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the decoded offset |
| cfg_legacy_base | input | 1 | Base address has bit 2 set; decode only two offset bits |
| cfg_ext | input | 1 | Extended bidirectional mode |
| cfg_epp | input | 1 | Enhanced address/data mode |
| cfg_ecp | input | 1 | Extended-capabilities mode |
| cfg_ecp_epp | input | 1 | Extended-capabilities port running its enhanced sub-mode |
| periph_present | input | 1 | A peripheral supplies status bits |
| periph_status | input | 5 | Peripheral status lines for bits 7:3 |
| periph_ctrl_valid | input | 1 | A peripheral supplies control read-back |
| periph_ctrl | input | 8 | Peripheral control read-back |
| ack_raise | input | 1 | Peripheral acknowledge raises the interrupt |
| ack_lower | input | 1 | Peripheral lowers the interrupt |
| pin_data | output | 8 | Data lines toward the peripheral |
| pin_strobe | output | 1 | Strobe line |
| pin_autofeed | output | 1 | Autofeed line |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions watch, on every cycle, the rules that tie a single access to its result. Bit 5 of a control read depends on the mode. Status bits 2:0 read all ones in compatibility mode. A status read in extended mode clears the pending flag. A pending flag never exists without the enable. Pins stay frozen while the direction bit is set in extended mode. Strobe follows the written byte. The full read-back values depend on peripheral read-back, the enhanced sub-mode, the legacy-base aliasing and the same-cycle priorities between raise, lower and clearing events, and only the bench's scenarios against its reference model can show these.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_HI_W = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ext;
        logic epp;
        logic ecp;
        logic ecp_epp;
    } mode_t;

    localparam int CB_STB = 0;
    localparam int CB_AFD = 1;
    localparam int CB_IE  = 4;
    localparam int CB_DIR = 5;

    localparam byte_t IE_MASK       = byte_t'(1) << CB_IE;
    localparam byte_t DIR_MASK      = byte_t'(1) << CB_DIR;
    localparam byte_t CTRL_FIXED_HI = 8'hC0;
    localparam byte_t DATA_RST      = 8'hFF;
    localparam byte_t CTRL_RST      = 8'h00;
    localparam byte_t OPEN_BUS      = 8'hFF;
    localparam logic [STAT_HI_W-1:0] STAT_HI_NONE = 5'b11011;

    function automatic logic mode_plain(input mode_t m);
        return !(m.epp || m.ecp);
    endfunction

    function automatic logic mode_epp_regs(input mode_t m);
        return m.epp || (m.ecp && m.ecp_epp);
    endfunction

endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              legacy,
    output reg_sel_e          sel
);
    localparam int NARROW_W = 2;

    logic [ADDR_W-1:0] off;

    always_comb begin
        if (legacy)
            off = {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
        else
            off = addr;
        case (off)
            ADDR_W'(0): sel = SEL_DATA;
            ADDR_W'(1): sel = SEL_STAT;
            ADDR_W'(2): sel = SEL_CTRL;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    input  mode_t mode,
    input  logic  rb_valid,
    input  byte_t rb_val,
    output byte_t ctrl_q,
    output logic  ie,
    output byte_t rd_val
);
    byte_t ie_byte;
    byte_t raw;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (wr_en)
            ctrl_q <= wdata;
    end

    assign ie      = ctrl_q[CB_IE];
    assign ie_byte = ie ? IE_MASK : '0;

    always_comb begin
        if (rb_valid)
            raw = (rb_val & ~IE_MASK) | ie_byte;
        else
            raw = CTRL_FIXED_HI | ctrl_q | ie_byte;
        raw = raw & ~DIR_MASK;

        rd_val = raw;
        if (mode_plain(mode))
            rd_val = rd_val | DIR_MASK;
        if (mode.ecp)
            rd_val[CB_AFD:CB_STB] = ctrl_q[CB_AFD:CB_STB];
    end
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
    input  logic clk,
    input  logic rst,
    input  logic ie,
    input  logic ctrl_wr,
    input  logic ctrl_wr_ie,
    input  logic stat_rd,
    input  logic ext,
    input  logic raise,
    input  logic lower,
    output logic pend
);
    logic clr;

    assign clr = (ctrl_wr && !ctrl_wr_ie) || (stat_rd && ext);

    always_ff @(posedge clk) begin
        if (rst || clr || !ie)
            pend <= 1'b0;
        else if (raise)
            pend <= 1'b1;
        else if (lower)
            pend <= 1'b0;
    end
endmodule

// File: rtl/pport_status.sv
module pport_status
    import pport_pkg::*;
(
    input  mode_t                 mode,
    input  logic                  pend,
    input  logic                  ie,
    input  logic                  present,
    input  logic [STAT_HI_W-1:0]  pstat,
    output byte_t                 rd_val
);
    logic [STAT_HI_W-1:0]        hi;
    logic [BYTE_W-STAT_HI_W-1:0] lo;

    always_comb begin
        hi = present ? pstat : STAT_HI_NONE;
        if (!mode_plain(mode))
            lo = {(ie ? !pend : 1'b1), 1'b1, !mode_epp_regs(mode)};
        else if (mode.ext)
            lo = {!pend, 2'b11};
        else
            lo = 3'b111;
        rd_val = {hi, lo};
    end
endmodule

// File: rtl/pport_data.sv
module pport_data
    import pport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wdata,
    input  logic  ext,
    input  logic  dir,
    output byte_t latch_q,
    output byte_t pins_q
);
    logic drive_ok;

    assign drive_ok = !ext || !dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= DATA_RST;
            pins_q  <= DATA_RST;
        end else if (wr_en) begin
            latch_q <= wdata;
            if (drive_ok)
                pins_q <= wdata;
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cfg_legacy_base,
    input  logic              cfg_ext,
    input  logic              cfg_epp,
    input  logic              cfg_ecp,
    input  logic              cfg_ecp_epp,
    input  logic              periph_present,
    input  logic [4:0]        periph_status,
    input  logic              periph_ctrl_valid,
    input  logic [7:0]        periph_ctrl,
    input  logic              ack_raise,
    input  logic              ack_lower,
    output logic [7:0]        pin_data,
    output logic              pin_strobe,
    output logic              pin_autofeed,
    output logic              irq
);
    reg_sel_e sel;
    mode_t    mode;
    byte_t    ctrl_q;
    byte_t    ctrl_rd;
    byte_t    stat_rd;
    byte_t    data_q;
    logic     ie;
    logic     dir;
    logic     pend;
    logic     wr_data, wr_ctrl, rd_stat;

    assign mode = '{ext: cfg_ext, epp: cfg_epp, ecp: cfg_ecp, ecp_epp: cfg_ecp_epp};

    pport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .legacy (cfg_legacy_base),
        .sel    (sel)
    );

    assign wr_data = bus_wr && (sel == SEL_DATA);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign rd_stat = bus_rd && (sel == SEL_STAT);

    pport_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ctrl),
        .wdata    (bus_wdata),
        .mode     (mode),
        .rb_valid (periph_ctrl_valid),
        .rb_val   (periph_ctrl),
        .ctrl_q   (ctrl_q),
        .ie       (ie),
        .rd_val   (ctrl_rd)
    );

    assign dir = ctrl_q[CB_DIR];

    pport_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .ie         (ie),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wr_ie (bus_wdata[CB_IE]),
        .stat_rd    (rd_stat),
        .ext        (cfg_ext),
        .raise      (ack_raise),
        .lower      (ack_lower),
        .pend       (pend)
    );

    pport_status u_stat (
        .mode    (mode),
        .pend    (pend),
        .ie      (ie),
        .present (periph_present),
        .pstat   (periph_status),
        .rd_val  (stat_rd)
    );

    pport_data u_data (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_data),
        .wdata   (bus_wdata),
        .ext     (cfg_ext),
        .dir     (dir),
        .latch_q (data_q),
        .pins_q  (pin_data)
    );

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = data_q;
            SEL_STAT: bus_rdata = stat_rd;
            SEL_CTRL: bus_rdata = ctrl_rd;
            default:  bus_rdata = OPEN_BUS;
        endcase
    end

    assign pin_strobe   = ctrl_q[CB_STB];
    assign pin_autofeed = ctrl_q[CB_AFD];
    assign irq          = pend;
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk
    import pport_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input reg_sel_e   sel,
    input logic       cfg_ext,
    input logic       cfg_epp,
    input logic       cfg_ecp,
    input logic       ie,
    input logic       dir,
    input logic [7:0] pin_data,
    input logic       pin_strobe,
    input logic       pin_autofeed,
    input logic       irq
);
    AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_data == 8'hFF && !irq && !pin_strobe && !pin_autofeed)); // R10

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie); // R9

    AST_STAT_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_STAT && cfg_ext) |=> !irq); // R6

    AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_ext && dir) |=> $stable(pin_data)); // R8

    AST_CTRL_BIT5_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_CTRL && !cfg_epp && !cfg_ecp) |-> bus_rdata[5]); // R3

    AST_CTRL_BIT5_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_CTRL && (cfg_epp || cfg_ecp)) |-> !bus_rdata[5]); // R2

    AST_STAT_LOW_COMPAT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_STAT && !cfg_ext && !cfg_epp && !cfg_ecp)
            |-> (bus_rdata[2:0] == 3'b111)); // R5

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_CTRL) |=> (pin_strobe == $past(bus_wdata[0]))); // R4
endmodule

bind pport_regs pport_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sel          (sel),
    .cfg_ext      (cfg_ext),
    .cfg_epp      (cfg_epp),
    .cfg_ecp      (cfg_ecp),
    .ie           (ie),
    .dir          (dir),
    .pin_data     (pin_data),
    .pin_strobe   (pin_strobe),
    .pin_autofeed (pin_autofeed),
    .irq          (irq)
);

// File: tb/tb_pport_regs.sv
module tb_pport_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cfg_legacy_base = 1'b0, cfg_ext = 1'b0, cfg_epp = 1'b0;
    logic       cfg_ecp = 1'b0, cfg_ecp_epp = 1'b0;
    logic       periph_present = 1'b0;
    logic [4:0] periph_status = '0;
    logic       periph_ctrl_valid = 1'b0;
    logic [7:0] periph_ctrl = '0;
    logic       ack_raise = 1'b0, ack_lower = 1'b0;
    logic [7:0] pin_data;
    logic       pin_strobe, pin_autofeed, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_regs #(.ADDR_W(3)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_legacy_base(cfg_legacy_base),
        .cfg_ext(cfg_ext), .cfg_epp(cfg_epp), .cfg_ecp(cfg_ecp), .cfg_ecp_epp(cfg_ecp_epp),
        .periph_present(periph_present), .periph_status(periph_status),
        .periph_ctrl_valid(periph_ctrl_valid), .periph_ctrl(periph_ctrl),
        .ack_raise(ack_raise), .ack_lower(ack_lower), .pin_data(pin_data),
        .pin_strobe(pin_strobe), .pin_autofeed(pin_autofeed), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [7:0] m_data = 8'hFF, m_pins = 8'hFF, m_ctrl = 8'h00;
    logic       m_pend = 1'b0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_off();
        return cfg_legacy_base ? int'(bus_addr[1:0]) : int'(bus_addr);
    endfunction

    function automatic logic [7:0] exp_read();
        int off = eff_off();
        logic [7:0] v;
        logic ie_m = m_ctrl[4];
        logic plain = !cfg_epp && !cfg_ecp;
        logic epp_regs = cfg_epp || (cfg_ecp && cfg_ecp_epp);
        v = 8'hFF;
        if (off == 0) v = m_data;
        else if (off == 1) begin
            v[7:3] = periph_present ? periph_status : 5'b11011;
            if (!plain) begin
                v[1] = 1'b1;
                v[0] = epp_regs ? 1'b0 : 1'b1;
                v[2] = ie_m ? ~m_pend : 1'b1;
            end else if (cfg_ext) v[2:0] = m_pend ? 3'd3 : 3'd7;
            else v[2:0] = 3'd7;
        end else if (off == 2) begin
            if (periph_ctrl_valid) v = (periph_ctrl & 8'hEF) | (ie_m ? 8'h10 : 8'h00);
            else v = 8'hC0 | m_ctrl | (ie_m ? 8'h10 : 8'h00);
            v = v & 8'hDF;
            if (plain) v = v | 8'h20;
            if (cfg_ecp) v = (v & 8'hFC) | (m_ctrl & 8'h03);
        end
        return v;
    endfunction

    task automatic model_update();
        int off = eff_off();
        logic clr;
        if (rst) begin
            m_data = 8'hFF; m_pins = 8'hFF; m_ctrl = 8'h00; m_pend = 1'b0;
            return;
        end
        clr = (bus_wr && off == 2 && !bus_wdata[4]) || (bus_rd && off == 1 && cfg_ext);
        if (clr || !m_ctrl[4]) m_pend = 1'b0;
        else if (ack_raise) m_pend = 1'b1;
        else if (ack_lower) m_pend = 1'b0;
        if (bus_wr && off == 0) begin
            if (!cfg_ext || !m_ctrl[5]) m_pins = bus_wdata;
            m_data = bus_wdata;
        end
        if (bus_wr && off == 2) m_ctrl = bus_wdata;
    endtask

    // one clock: compare outputs against the model, then advance both
    task automatic tick(input string req);
        #1;
        if (bus_rd) check(req, bus_rdata, exp_read());
        check("R8 pins", pin_data, m_pins);
        check("R4 lines", {6'b0, pin_autofeed, pin_strobe}, {6'b0, m_ctrl[1], m_ctrl[0]});
        check("R9 irq", {7'b0, irq}, {7'b0, m_pend});
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] v, input string req);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        tick(req);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        tick(req);
        bus_rd = 1'b0;
    endtask

    task automatic do_raise(input string req);
        ack_raise = 1'b1;
        tick(req);
        ack_raise = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R10: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) tick("R10");
        rst = 1'b0;

        // R10 reset values, R3 and R5 compatibility read-back
        do_rd(3'd0, 8'hFF, "R10 data after reset");
        do_rd(3'd2, 8'hE0, "R3 ctrl after reset");
        do_rd(3'd1, 8'hDF, "R5 status no peripheral");

        // R8 compatibility data write
        do_wr(3'd0, 8'h5A, "R8");
        do_rd(3'd0, 8'h5A, "R8 latch read");
        check("R8 pins drive", pin_data, 8'h5A);

        // R4 control write drives strobe and autofeed, R3 bit 5 forced
        do_wr(3'd2, 8'h03, "R4");
        check("R4 strobe/autofeed", {6'b0, pin_autofeed, pin_strobe}, 8'h03);
        do_rd(3'd2, 8'hE3, "R3 ctrl compat");

        // R5 peripheral status upper bits
        periph_present = 1'b1; periph_status = 5'b10100;
        do_rd(3'd1, 8'hA7, "R5 status with peripheral");
        periph_present = 1'b0;

        // R2 peripheral control read-back, R3 ECP low bits
        periph_ctrl_valid = 1'b1; periph_ctrl = 8'h3C;
        do_rd(3'd2, 8'h2C, "R2 periph ctrl compat");
        cfg_ecp = 1'b1;
        do_rd(3'd2, 8'h0F, "R3 ecp ctrl low bits");
        cfg_ecp = 1'b0; periph_ctrl_valid = 1'b0;

        // R9 interrupt raise/lower while enabled and disabled
        do_raise("R9 raise disabled");
        check("R9 no pend without enable", {7'b0, irq}, 8'h00);
        do_wr(3'd2, 8'h10, "R4 enable irq");
        do_raise("R9 raise");
        check("R9 pend set", {7'b0, irq}, 8'h01);
        ack_lower = 1'b1; tick("R9 lower"); ack_lower = 1'b0;
        check("R9 pend cleared", {7'b0, irq}, 8'h00);
        ack_raise = 1'b1; ack_lower = 1'b1; tick("R9 both"); ack_raise = 1'b0; ack_lower = 1'b0;
        check("R9 raise wins", {7'b0, irq}, 8'h01);
        do_rd(3'd1, 8'hDF, "R5 compat read keeps bits");
        check("R9 compat read no clear", {7'b0, irq}, 8'h01);
        do_wr(3'd2, 8'h00, "R4 disable clears");
        check("R4 pend cleared by write", {7'b0, irq}, 8'h00);

        // R8 and R6 extended mode
        cfg_ext = 1'b1;
        do_wr(3'd2, 8'h30, "R4 ie+dir");
        do_wr(3'd0, 8'h11, "R8 ext dir write");
        check("R8 pins hold", pin_data, 8'h5A);
        do_rd(3'd0, 8'h11, "R8 latch ext");
        do_raise("R6 raise");
        do_rd(3'd1, 8'hDB, "R6 status pending");
        do_rd(3'd1, 8'hDF, "R6 cleared by read");
        do_raise("R6 raise again");
        ack_raise = 1'b1;
        do_rd(3'd1, 8'hDB, "R6 read with raise");
        ack_raise = 1'b0;
        check("R6 clear beats raise", {7'b0, irq}, 8'h00);
        do_wr(3'd2, 8'h10, "R4 dir off");
        do_wr(3'd0, 8'h22, "R8 ext output");
        check("R8 pins ext output", pin_data, 8'h22);
        cfg_ext = 1'b0;

        // R7 enhanced status bits, R2 raw control bit 5
        cfg_epp = 1'b1;
        do_raise("R7 raise");
        do_rd(3'd1, 8'hDA, "R7 epp pending");
        do_rd(3'd2, 8'hD0, "R2 epp ctrl raw");
        do_wr(3'd2, 8'h00, "R4 ie off");
        do_rd(3'd1, 8'hDE, "R7 epp ie off");
        cfg_epp = 1'b0; cfg_ecp = 1'b1;
        do_rd(3'd1, 8'hDF, "R7 ecp plain");
        cfg_ecp_epp = 1'b1;
        do_rd(3'd1, 8'hDE, "R7 ecp epp sub-mode");
        cfg_ecp = 1'b0; cfg_ecp_epp = 1'b0;

        // R1 decode and legacy aliasing
        do_rd(3'd3, 8'hFF, "R1 offset 3");
        do_wr(3'd4, 8'h77, "R1 write ignored");
        do_rd(3'd0, 8'h22, "R1 data unchanged");
        do_rd(3'd6, 8'hFF, "R1 offset 6 wide");
        cfg_legacy_base = 1'b1;
        do_rd(3'd6, 8'hE0, "R1 legacy alias ctrl");
        do_wr(3'd4, 8'h99, "R1 legacy data write");
        do_rd(3'd0, 8'h99, "R1 legacy data");
        do_rd(3'd7, 8'hFF, "R1 legacy offset 3");
        cfg_legacy_base = 1'b0;

        // R10 reset again after activity
        rst = 1'b1; tick("R10"); rst = 1'b0;
        do_rd(3'd0, 8'hFF, "R10 data reset");
        check("R10 pins reset", pin_data, 8'hFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule